// File: doc/BRIEF.md
# Three-Channel Interval Timer Bank

This block holds three independent 16-bit down-counters behind a byte-wide register interface. A 2-bit port address selects one of the three counter ports (0 to 2) or the write-only control port (3). Software writes a control word to pick a channel and either program its mode or take a snapshot of its count. It then writes a reload value as two bytes and reads the count back one byte per access.

All counters advance together on a shared tick-enable input. A loaded counter steps down from its reload value to 1 and then starts again at the reload value. Channel 0 drives a one-cycle interrupt pulse when it expires. In rate mode it pulses on every expiry. In the other accepted modes it pulses only on the first expiry after each reload.

Top module: `interval_timer_bank`

## Requirements
- R1: After a synchronous reset, `irq` and `rd_data` are 0, and every channel is unloaded: a counter read returns 0 and its count does not move on ticks.
- R2: A reload value is written to a counter port as two bytes, low byte first. The counter is loaded and restarts only when the high byte arrives; before that the old count is unchanged.
- R3: While `tick_en` is high, a loaded count decreases by one per cycle. From 1 it returns to the reload value. The value read is therefore the reload minus the elapsed ticks modulo the reload.
- R4: A reload value of 0 is loaded as 16'hFFFF.
- R5: A control word with access bits [5:4] = 2'b00 snapshots the selected channel's count (channel in bits [7:6]). The next two reads of that channel return the low byte and then the high byte of the snapshot. After that, reads follow the live count again.
- R6: A snapshot command is ignored while a previous snapshot still has bytes left to read.
- R7: With no snapshot pending, successive reads of a channel alternate between the low and the high byte of the live count, starting with the low byte. Completing a reload makes the next such read a low byte again.
- R8: A control word with channel bits [7:6] = 2'b11 has no effect on any channel.
- R9: Control words with access bits [5:4] = 2'b01 or 2'b10 have no effect.
- R10: A control word with access bits 2'b11 is accepted only if mode bits [3:0] are 4'h0 (one-shot), 4'h4 (rate), 4'h6 (square wave) or 4'h8 (strobe). Any other mode value leaves the channel completely unchanged, including a pending snapshot.
- R11: An accepted control word with access bits 2'b11 discards any pending snapshot of that channel.
- R12: `irq` is high for exactly one cycle per expiry of channel 0 (a tick while its count is 1), one cycle after that tick. In rate mode (4'h4) every expiry pulses. In any other mode only the first expiry after a reload pulses.
- R13: Read data is registered and appears in the cycle after `rd_en`. A read of the control port returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-enable shared by all channels |
| addr | input | 2 | Port select: 0 to 2 counters, 3 control |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte |
| irq | output | 1 | Channel 0 expiry pulse |

## Verification
The bench builds the block with its default parameters: three channels, 8-bit bytes, and only channel 0 feeding the interrupt. Reload values of 3 and 5 bring several wraps, and the one-shot disarm after the first expiry, within a dozen ticks. A zero reload is checked at its 16'hFFFF load value and over its first few decrements. Channel 1 carries the snapshot and control-word rejection cases, so any misrouting of a command to the wrong channel shows up as a wrong byte order or a lost snapshot.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  typedef enum logic [1:0] {
    ACC_SNAP = 2'b00,
    ACC_LOW  = 2'b01,
    ACC_HIGH = 2'b10,
    ACC_WORD = 2'b11
  } access_e;

  typedef enum logic [3:0] {
    MD_ONESHOT = 4'h0,
    MD_RATE    = 4'h4,
    MD_SQUARE  = 4'h6,
    MD_STROBE  = 4'h8
  } mode_e;

  typedef struct packed {
    logic [1:0] chan;
    access_e    acc;
    logic [3:0] mode;
  } ctl_word_t;

  localparam logic [1:0] CHAN_REJECT = 2'b11;

  function automatic logic mode_accepted(input logic [3:0] m);
    return (m == MD_ONESHOT) || (m == MD_RATE) ||
           (m == MD_SQUARE)  || (m == MD_STROBE);
  endfunction

endpackage

// File: rtl/ivt_ctl_decode.sv
module ivt_ctl_decode
  import ivt_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [NUM_CH-1:0] snap_req,
  output logic [NUM_CH-1:0] prog_req,
  output logic [3:0]        prog_mode
);

  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH);

  ctl_word_t cw;
  logic      ctl_hit;

  assign cw        = ctl_word_t'(wr_data);
  assign ctl_hit   = wr_en && (addr == CTL_ADDR) && (cw.chan != CHAN_REJECT);
  assign prog_mode = cw.mode;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      snap_req[i] = ctl_hit && (cw.chan == 2'(i)) && (cw.acc == ACC_SNAP);
      prog_req[i] = ctl_hit && (cw.chan == 2'(i)) && (cw.acc == ACC_WORD) &&
                    mode_accepted(cw.mode);
    end
  end

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              rd_stb,
  input  logic              snap_req,
  input  logic              prog_req,
  input  logic [3:0]        prog_mode,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              expire_o
);

  localparam int          CNT_W    = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic              loaded, armed;
  logic [3:0]        mode_q;
  logic [CNT_W-1:0]  reload_q, cnt_q, snap_q;
  logic [BYTE_W-1:0] low_stage;
  logic              wr_high, rd_high;
  logic [1:0]        snap_left;

  logic              load_fire, expiry;
  logic [CNT_W-1:0]  new_reload;

  assign load_fire  = wr_stb && wr_high;
  assign new_reload = ({wr_byte, low_stage} == '0) ? CNT_MAX : {wr_byte, low_stage};
  assign expiry     = loaded && tick_en && !load_fire && (cnt_q == CNT_ONE);

  // Byte pointer and reload register
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_high   <= 1'b0;
      low_stage <= '0;
      reload_q  <= '0;
      loaded    <= 1'b0;
    end else if (wr_stb) begin
      if (!wr_high) begin
        low_stage <= wr_byte;
        wr_high   <= 1'b1;
      end else begin
        wr_high  <= 1'b0;
        reload_q <= new_reload;
        loaded   <= 1'b1;
      end
    end
  end

  // Live down-counter
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_fire) begin
      cnt_q <= new_reload;
    end else if (loaded && tick_en) begin
      cnt_q <= (cnt_q == CNT_ONE) ? reload_q : cnt_q - CNT_ONE;
    end
  end

  // Mode, arming and expiry pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MD_ONESHOT;
      armed    <= 1'b0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= expiry && armed;
      if (prog_req) mode_q <= prog_mode;
      if (load_fire) armed <= 1'b1;
      else if (expiry && (mode_q != MD_RATE)) armed <= 1'b0;
    end
  end

  // Snapshot latch and byte toggles
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q    <= '0;
      snap_left <= 2'd0;
      rd_high   <= 1'b0;
    end else begin
      if (prog_req) begin
        snap_left <= 2'd0;
      end else if (snap_req && (snap_left == 2'd0)) begin
        snap_q    <= cnt_q;
        snap_left <= 2'd2;
      end else if (rd_stb && (snap_left != 2'd0)) begin
        snap_left <= snap_left - 2'd1;
      end
      if (load_fire) rd_high <= 1'b0;
      else if (rd_stb && (snap_left == 2'd0)) rd_high <= ~rd_high;
    end
  end

  always_comb begin
    if (snap_left == 2'd2)      rd_byte = snap_q[BYTE_W-1:0];
    else if (snap_left == 2'd1) rd_byte = snap_q[CNT_W-1:BYTE_W];
    else if (rd_high)           rd_byte = cnt_q[CNT_W-1:BYTE_W];
    else                        rd_byte = cnt_q[BYTE_W-1:0];
  end

  // Assertions
  assert_nonzero_count_R4: assert property (@(posedge clk) disable iff (rst)
    loaded |-> (cnt_q != '0));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (loaded && tick_en && !wr_stb && (cnt_q > CNT_ONE)) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

  assert_snap_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ((snap_left != 2'd0) && !prog_req && !rd_stb) |=> ($stable(snap_q) && $stable(snap_left)));

  assert_restart_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !wr_high && !tick_en) |=> $stable(cnt_q));

  assert_snap_drop_R11: assert property (@(posedge clk) disable iff (rst)
    prog_req |=> (snap_left == 2'd0));

endmodule

// File: rtl/ivt_read_mux.sv
module ivt_read_mux #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] ch_byte [NUM_CH],
  output logic [BYTE_W-1:0] rd_data
);

  logic [BYTE_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr == ADDR_W'(i)) pick = ch_byte[i];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= pick;
  end

  assert_ctl_read_zero_R13: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == ADDR_W'(NUM_CH))) |=> (rd_data == '0));

  assert_read_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/interval_timer_bank.sv
module interval_timer_bank #(
  parameter int                NUM_CH      = 3,
  parameter int                BYTE_W      = 8,
  parameter logic [NUM_CH-1:0] IRQ_CH_MASK = NUM_CH'(1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick_en,
  input  logic [$clog2(NUM_CH+1)-1:0] addr,
  input  logic                        wr_en,
  input  logic [BYTE_W-1:0]           wr_data,
  input  logic                        rd_en,
  output logic [BYTE_W-1:0]           rd_data,
  output logic                        irq
);

  localparam int ADDR_W = $clog2(NUM_CH + 1);

  logic [NUM_CH-1:0] snap_req, prog_req, expire, wr_stb, rd_stb;
  logic [3:0]        prog_mode;
  logic [BYTE_W-1:0] ch_byte [NUM_CH];

  ivt_ctl_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data[7:0]),
    .snap_req (snap_req),
    .prog_req (prog_req),
    .prog_mode(prog_mode)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign wr_stb[g] = wr_en && (addr == ADDR_W'(g));
    assign rd_stb[g] = rd_en && (addr == ADDR_W'(g));

    ivt_channel #(.BYTE_W(BYTE_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .tick_en  (tick_en),
      .wr_stb   (wr_stb[g]),
      .wr_byte  (wr_data),
      .rd_stb   (rd_stb[g]),
      .snap_req (snap_req[g]),
      .prog_req (prog_req[g]),
      .prog_mode(prog_mode),
      .rd_byte  (ch_byte[g]),
      .expire_o (expire[g])
    );
  end

  assign irq = |(expire & IRQ_CH_MASK);

  ivt_read_mux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .addr   (addr),
    .ch_byte(ch_byte),
    .rd_data(rd_data)
  );

  assert_single_target_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(snap_req | prog_req));

  assert_reject_chan_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_W'(NUM_CH)) && (wr_data[7:6] == 2'b11)) |-> ((snap_req | prog_req) == '0));

  assert_reject_access_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_W'(NUM_CH)) && (wr_data[5:4] inside {2'b01, 2'b10})) |-> ((snap_req | prog_req) == '0));

  assert_irq_after_tick_R12: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(tick_en));

endmodule

// File: tb/interval_timer_bank_bench.sv
module interval_timer_bank_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int compared = 0;
  int mismatched = 0;
  int irq_seen = 0;
  bit finished = 0;
  logic rd_fl = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  interval_timer_bank u_interval_timer_bank (
    .clk(clk), .rst(rst), .tick_en(tick_en), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // Monitor: compares registered read data against the scoreboard queue
  always @(posedge clk) rd_fl <= rd_en;
  always @(negedge clk) begin
    if (irq) irq_seen++;
    if (rd_fl && !rst) begin
      if (exp_q.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R13: actual %0h expected none (unexpected read)", rd_data);
      end else begin
        check({24'd0, rd_data}, {24'd0, exp_q.pop_front()}, tag_q.pop_front());
      end
    end
  end

  task automatic put(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic get(input logic [1:0] a, input logic [7:0] exp, input string tag);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({31'd0, irq}, 0, "R1 irq");
    check({24'd0, rd_data}, 0, "R1 rd_data");
    get(2'd0, 8'h00, "R1 unloaded low");
    get(2'd0, 8'h00, "R1 unloaded high");
    get(2'd3, 8'h00, "R13 control read");

    // R2 two-byte reload on channel 0, rate mode
    put(2'd3, 8'h34);
    put(2'd0, 8'h05);
    get(2'd0, 8'h00, "R2 before high byte");
    put(2'd0, 8'h00);
    get(2'd0, 8'h05, "R2 loaded low");
    get(2'd0, 8'h00, "R7 alternate high");
    get(2'd0, 8'h05, "R7 alternate low");

    // R5/R6 snapshot
    ticks(2);
    put(2'd3, 8'h00);
    ticks(1);
    get(2'd0, 8'h03, "R5 snapshot low");
    put(2'd3, 8'h00);
    get(2'd0, 8'h00, "R6 second snapshot ignored");
    get(2'd0, 8'h00, "R7 live high after snapshot");
    get(2'd0, 8'h02, "R7 live low");

    // R12 rate mode expiries
    ticks(2);
    ticks(5);
    @(negedge clk);
    check(irq_seen, 2, "R12 rate irq count");

    // R12 one-shot: single pulse per reload
    put(2'd3, 8'h30);
    put(2'd0, 8'h03);
    put(2'd0, 8'h00);
    ticks(10);
    @(negedge clk);
    check(irq_seen, 3, "R12 one-shot irq count");
    get(2'd0, 8'h02, "R3 wrapped count low");
    get(2'd0, 8'h00, "R3 wrapped count high");

    // R4 zero reload on channel 1
    put(2'd3, 8'h74);
    put(2'd1, 8'h00);
    put(2'd1, 8'h00);
    get(2'd1, 8'hFF, "R4 max low");
    get(2'd1, 8'hFF, "R4 max high");
    ticks(1);
    get(2'd1, 8'hFE, "R3 decrement from max");

    // R8 read-back select rejected
    put(2'd3, 8'h40);
    ticks(1);
    put(2'd3, 8'hF4);
    get(2'd1, 8'hFE, "R8 snapshot kept low");
    get(2'd1, 8'hFF, "R8 snapshot kept high");

    // R9 partial access types ignored
    put(2'd3, 8'h40);
    put(2'd3, 8'h54);
    put(2'd3, 8'h64);
    get(2'd1, 8'hFD, "R9 snapshot kept low");
    get(2'd1, 8'hFF, "R9 snapshot kept high");

    // R10 invalid modes rejected
    put(2'd3, 8'h40);
    put(2'd3, 8'h72);
    put(2'd3, 8'h75);
    get(2'd1, 8'hFD, "R10 snapshot kept low");
    get(2'd1, 8'hFF, "R10 snapshot kept high");

    // R11 valid programming discards snapshot
    put(2'd3, 8'h40);
    ticks(1);
    put(2'd3, 8'h74);
    get(2'd1, 8'hFF, "R11 live high");
    get(2'd1, 8'hFC, "R11 live low");

    // R2/R7 channel 2 pointer and toggle reset
    put(2'd3, 8'hB4);
    put(2'd2, 8'h34);
    ticks(3);
    get(2'd2, 8'h00, "R2 unloaded while half written");
    put(2'd2, 8'h12);
    get(2'd2, 8'h34, "R2 loaded low");
    put(2'd2, 8'h10);
    put(2'd2, 8'h00);
    get(2'd2, 8'h10, "R7 toggle reset low");
    get(2'd2, 8'h00, "R7 toggle reset high");
    get(2'd3, 8'h00, "R13 control read late");

    @(negedge clk);
    @(negedge clk);
    check(irq_seen, 3, "R12 no further one-shot pulses");
    check(exp_q.size(), 0, "R13 all reads returned");
    finished = 1;
    summary();
  end

endmodule